// File: doc/BRIEF.md
# Gated Event Counter with End-of-Gate Capture

This block counts events of a chosen kind while a chosen gate window is open. The event source can be the start of a video line, the start of a video frame, or a free-running microsecond tick. The gate source can be the line-valid window, the frame-valid window, a trigger envelope, or an acquisition-active window. Both selections are run-time inputs.

Two values leave the block. The first is a live count, which shows progress inside the current gate. The second is a held count, which is the value the live counter reached when the last gate closed. With frame gating and line events, the live value is the line number within the frame and the held value is the line total of the previous frame. All inputs are synchronous to the block clock.

Top module: `gated_event_counter`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `live_count` and `held_count` both read zero.
- R2: When `evt_sel` is 0 (line events), one count is taken per rising edge of `line_valid`. How long `line_valid` stays high does not change the count.
- R3: When `evt_sel` is 1 (frame events), one count is taken per rising edge of `frame_valid`.
- R4: When `evt_sel` is 2 (microsecond events), one count is taken for every clock cycle in which `usec_tick` is high. When `evt_sel` is 3, nothing is counted.
- R5: Events are ignored while the selected gate is low, and `live_count` keeps its value.
- R6: On a rising edge of the selected gate, `live_count` restarts. It becomes 1 if an event is present in that same cycle, and 0 otherwise.
- R7: On a falling edge of the selected gate, `held_count` takes the value of `live_count` from that cycle. The new value is visible one clock later. At all other times `held_count` is unchanged.
- R8: `gate_sel` selects the gate as follows: 0 selects `line_valid`, 1 selects `frame_valid`, 2 selects `trig_env`, and 3 selects `acq_active`.
- R9: `live_count` saturates at all ones and does not wrap.
- R10: With `gate_sel` set to 1 and `evt_sel` set to 0, `live_count` tracks the line number within the current frame, and `held_count` holds the line total of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| line_valid | input | 1 | Line-valid level |
| frame_valid | input | 1 | Frame-valid level |
| trig_env | input | 1 | Trigger envelope level |
| acq_active | input | 1 | Acquisition-active level |
| usec_tick | input | 1 | Microsecond tick, one count per high cycle |
| evt_sel | input | 2 | Event source select: 0 line, 1 frame, 2 microsecond, 3 none |
| gate_sel | input | 2 | Gate source select: 0 line, 1 frame, 2 trigger, 3 acquisition |
| live_count | output | CNT_W | Running count within the current gate |
| held_count | output | CNT_W | Final count of the previous gate |

## Verification
The bench applies line pulses of several lengths inside a frame gate, to show that counting follows edges rather than levels. It also sends line pulses while the gate is closed, to show that they are ignored. Frame pulses are tried under the acquisition gate, and a broken run of microsecond ticks is tried under the trigger gate, which tells level counting apart from edge counting. A tick that arrives in the same cycle the gate opens checks that the restart includes it. A four-bit copy of the block driven past its limit separates saturation from wrap-around.

// File: rtl/gec_pkg.sv
package gec_pkg;

    typedef enum logic [1:0] {
        EVT_LINE  = 2'd0,
        EVT_FRAME = 2'd1,
        EVT_USEC  = 2'd2,
        EVT_NONE  = 2'd3
    } evt_sel_e;

    typedef enum logic [1:0] {
        GATE_LINE  = 2'd0,
        GATE_FRAME = 2'd1,
        GATE_TRIG  = 2'd2,
        GATE_ACQ   = 2'd3
    } gate_sel_e;

    // index of each level input inside the edge-detector vector
    localparam int SRC_LINE  = 0;
    localparam int SRC_FRAME = 1;
    localparam int SRC_TRIG  = 2;
    localparam int SRC_ACQ   = 3;
    localparam int NUM_SRC   = 4;

    typedef struct packed {
        logic on;     // selected gate level
        logic start;  // selected gate rising this cycle
        logic fin;    // selected gate falling this cycle
    } gate_ctl_t;

    function automatic int gate_index(gate_sel_e g);
        case (g)
            GATE_LINE:  return SRC_LINE;
            GATE_FRAME: return SRC_FRAME;
            GATE_TRIG:  return SRC_TRIG;
            default:    return SRC_ACQ;
        endcase
    endfunction

endpackage

// File: rtl/gec_edge.sv
module gec_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end
endmodule

// File: rtl/gec_select.sv
module gec_select
    import gec_pkg::*;
(
    input  logic [NUM_SRC-1:0] lvl,
    input  logic [NUM_SRC-1:0] rise,
    input  logic [NUM_SRC-1:0] fall,
    input  logic               usec_tick,
    input  evt_sel_e           evt_sel,
    input  gate_sel_e          gate_sel,
    output logic               evt,
    output gate_ctl_t          gate
);
    int gi;

    always_comb begin
        gi         = gate_index(gate_sel);
        gate.on    = lvl[gi];
        gate.start = rise[gi];
        gate.fin   = fall[gi];
    end

    always_comb begin
        case (evt_sel)
            EVT_LINE:  evt = rise[SRC_LINE];
            EVT_FRAME: evt = rise[SRC_FRAME];
            EVT_USEC:  evt = usec_tick;
            default:   evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/gec_counter.sv
module gec_counter
    import gec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  gate_ctl_t        gate,
    output logic [CNT_W-1:0] live_q,
    output logic [CNT_W-1:0] held_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;
    assign at_max = (live_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            held_q <= '0;
        end else begin
            if (gate.start)
                live_q <= {{(CNT_W-1){1'b0}}, evt};
            else if (gate.on && evt && !at_max)
                live_q <= live_q + 1'b1;
            if (gate.fin)
                held_q <= live_q;
        end
    end

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q == CNT_MAX && !gate.start) |=> live_q == CNT_MAX);

    // R6
    gate_restart_chk: assert property (@(posedge clk) disable iff (rst)
        gate.start |=> live_q <= 1);

    // R5
    closed_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate.on && !gate.start) |=> $stable(live_q));

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        gate.fin |=> held_q == $past(live_q));

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !gate.fin |=> $stable(held_q));
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
    import gec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_valid,
    input  logic             frame_valid,
    input  logic             trig_env,
    input  logic             acq_active,
    input  logic             usec_tick,
    input  logic [1:0]       evt_sel,
    input  logic [1:0]       gate_sel,
    output logic [CNT_W-1:0] live_count,
    output logic [CNT_W-1:0] held_count
);
    logic [NUM_SRC-1:0] src_lvl, src_rise, src_fall;
    logic               evt;
    gate_ctl_t          gate;

    always_comb begin
        src_lvl            = '0;
        src_lvl[SRC_LINE]  = line_valid;
        src_lvl[SRC_FRAME] = frame_valid;
        src_lvl[SRC_TRIG]  = trig_env;
        src_lvl[SRC_ACQ]   = acq_active;
    end

    gec_edge #(.N(NUM_SRC)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (src_lvl),
        .rise (src_rise),
        .fall (src_fall)
    );

    gec_select u_sel (
        .lvl       (src_lvl),
        .rise      (src_rise),
        .fall      (src_fall),
        .usec_tick (usec_tick),
        .evt_sel   (evt_sel_e'(evt_sel)),
        .gate_sel  (gate_sel_e'(gate_sel)),
        .evt       (evt),
        .gate      (gate)
    );

    gec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .gate   (gate),
        .live_q (live_count),
        .held_q (held_count)
    );
endmodule

// File: tb/gated_event_counter_test.sv
module gated_event_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_valid = 0, frame_valid = 0, trig_env = 0, acq_active = 0, usec_tick = 0;
    logic [1:0]  evt_sel = 0, gate_sel = 0;
    logic [31:0] live_count, held_count;
    logic [3:0]  sat_live, sat_held;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    gated_event_counter uut (
        .clk(clk), .rst(rst), .line_valid(line_valid), .frame_valid(frame_valid),
        .trig_env(trig_env), .acq_active(acq_active), .usec_tick(usec_tick),
        .evt_sel(evt_sel), .gate_sel(gate_sel),
        .live_count(live_count), .held_count(held_count));

    gated_event_counter #(.CNT_W(4)) uut_sat (
        .clk(clk), .rst(rst), .line_valid(line_valid), .frame_valid(frame_valid),
        .trig_env(trig_env), .acq_active(acq_active), .usec_tick(usec_tick),
        .evt_sel(evt_sel), .gate_sel(gate_sel),
        .live_count(sat_live), .held_count(sat_held));

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic line_pulse(int width);
        line_valid = 1; tick(width);
        line_valid = 0; tick();
    endtask

    task automatic t_reset;
        rst = 1; tick(3);
        check("R1 live in reset", live_count, 0);
        check("R1 held in reset", held_count, 0);
        rst = 0; tick();
        check("R1 live after reset", live_count, 0);
        check("R1 held after reset", held_count, 0);
    endtask

    // R10, R2, R6, R7: frame gate with line events
    task automatic t_frame_lines;
        evt_sel = 2'd0; gate_sel = 2'd1;
        frame_valid = 1; tick();
        check("R6 open without event", live_count, 0);
        line_pulse(1); line_pulse(3); line_pulse(2);
        check("R2 edge counting", live_count, 3);
        line_pulse(1); line_pulse(4);
        check("R10 line number", live_count, 5);
        frame_valid = 0; tick();
        check("R7 held after frame", held_count, 5);
        check("R10 live kept", live_count, 5);
        frame_valid = 1; tick();
        check("R6 restart", live_count, 0);
        check("R10 previous total", held_count, 5);
        line_pulse(2); line_pulse(1);
        frame_valid = 0; tick();
        check("R7 second frame", held_count, 2);
    endtask

    // R5: line events while the frame gate is closed
    task automatic t_outside;
        evt_sel = 2'd0; gate_sel = 2'd1;
        line_pulse(1); line_pulse(2); line_pulse(1);
        check("R5 ignored outside gate", live_count, 2);
        check("R7 held unchanged", held_count, 2);
    endtask

    // R3, R8: frame events with the acquisition gate
    task automatic t_frame_events;
        evt_sel = 2'd1; gate_sel = 2'd3;
        acq_active = 1; tick();
        check("R6 acq open", live_count, 0);
        for (int i = 0; i < 4; i++) begin
            frame_valid = 1; tick(3);
            frame_valid = 0; tick();
        end
        check("R3 frame count", live_count, 4);
        acq_active = 0; tick();
        check("R8 acq gate held", held_count, 4);
    endtask

    // R4, R6, R8: microsecond ticks with the trigger gate
    task automatic t_usec_trig;
        evt_sel = 2'd2; gate_sel = 2'd2;
        trig_env = 1; usec_tick = 1; tick();
        check("R6 event on opening", live_count, 1);
        tick(5);
        check("R4 level counting", live_count, 6);
        usec_tick = 0; tick(2);
        usec_tick = 1; tick(2);
        check("R4 broken ticks", live_count, 8);
        usec_tick = 0; trig_env = 0; tick();
        check("R8 trigger gate held", held_count, 8);
        evt_sel = 2'd3; trig_env = 1; usec_tick = 1; tick(3);
        check("R4 no event select", live_count, 0);
        usec_tick = 0; trig_env = 0; tick();
    endtask

    // R8: line gate with microsecond ticks
    task automatic t_line_gate;
        evt_sel = 2'd2; gate_sel = 2'd0;
        line_valid = 1; usec_tick = 1; tick(7);
        line_valid = 0; usec_tick = 0; tick();
        check("R8 line gate held", held_count, 7);
    endtask

    // R9: saturation on the narrow copy
    task automatic t_saturate;
        evt_sel = 2'd2; gate_sel = 2'd3;
        acq_active = 1; usec_tick = 1; tick(20);
        check("R9 saturated live", sat_live, 15);
        check("R9 wide reference", live_count, 20);
        acq_active = 0; usec_tick = 0; tick();
        check("R9 saturated held", sat_held, 15);
    endtask

    initial begin
        tick();
        t_reset();
        t_frame_lines();
        t_outside();
        t_frame_events();
        t_usec_trig();
        t_line_gate();
        t_saturate();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule